// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status byte of a serial flash device and decides, one command at a time, whether a write-class operation may start. A command decoder ahead of it raises a single-cycle strobe for each decoded command. These commands are set-latch, clear-latch, status write, page program, sector erase, block erase and chip erase. It also presents the target address and the status-write payload. The block answers with a one-cycle accept or reject pulse. It raises a busy bit for the whole self-timed operation, and it drops the busy bit and the write latch when the array engine signals completion.

Protection has two layers. A three-bit protect code marks a top-aligned region of the array as read-only. A lock bit, together with an active-low write-protect pin held low, freezes the protect code and the lock bit itself. No data stream crosses this block, so every pin is a plain control or status signal with no handshake. The status byte stays readable in every cycle, including while an operation is running.

Top module: `srp_status_guard`

## Requirements
- R1: After reset the status byte is 00h. Its layout is bit 0 busy, bit 1 write latch, bits 4:2 protect code, bit 7 lock, and bits 6:5 always 0.
- R2: A set-latch strobe makes the write latch 1 and a clear-latch strobe makes it 0 at the next edge. Both strobes are ignored while busy is 1.
- R3: A program, erase or status-write strobe seen while the write latch is 0 gives a reject pulse and leaves the status byte unchanged.
- R4: The prot_o flag reflects the current address and protect code combinationally. Code 0 protects nothing, code 1 protects the top block (one quarter of the default four-block array), code 2 the top half, and codes 3 to 7 the whole array.
- R5: A program, sector erase or block erase whose address has prot_o set is rejected, and the write latch keeps its value.
- R6: Chip erase is accepted only when the protect code is 000; any other code rejects it.
- R7: When the lock bit is 1 and wp_n_i is 0, a status write is rejected and the protect code and lock bit are unchanged. With wp_n_i at 1, only the protect code limits writes.
- R8: An accepted command gives an accept pulse in the cycle after its strobe and sets busy at that same edge. An accepted status write loads the protect code and lock bit at that edge.
- R9: cycle_done_i while busy is 1 clears both busy and the write latch at the next edge.
- R10: Any program, erase or status-write strobe while busy is 1 is rejected.
- R11: Every strobe is judged against the state before the edge. A set-latch strobe that coincides with cycle_done_i is ignored, so the latch ends 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| set_latch_i | input | 1 | Set-latch command strobe |
| clr_latch_i | input | 1 | Clear-latch command strobe |
| sr_write_i | input | 1 | Status-write command strobe |
| page_prog_i | input | 1 | Page program strobe |
| sect_erase_i | input | 1 | Sector erase strobe |
| blk_erase_i | input | 1 | Block erase strobe |
| chip_erase_i | input | 1 | Chip erase strobe |
| addr_i | input | ADDR_W | Target address of program or erase |
| wr_code_i | input | 3 | Protect code carried by a status write |
| wr_lock_i | input | 1 | Lock bit carried by a status write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cycle_done_i | input | 1 | Self-timed operation finished |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Command accepted pulse |
| reject_o | output | 1 | Command rejected pulse |
| prot_o | output | 1 | Address falls in protected region |

## Verification
Completion of a running operation and a newly decoded command can land in the same cycle. The bench provokes this by raising cycle_done_i together with a set-latch strobe, and again together with a program strobe. A behavioural model judges each command on the state before the edge, so it expects the latch to end at 0 and the program to be rejected, with busy cleared in both cases. The model is compared against every output on every clock.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int SR_W        = 8;
  localparam int BIT_BUSY    = 0;
  localparam int BIT_LATCH   = 1;
  localparam int BIT_CODE_LO = 2;
  localparam int BIT_LOCK    = 7;
  localparam int CODE_W      = 3;

  typedef struct packed {
    logic set_latch;
    logic clr_latch;
    logic sr_write;
    logic page_prog;
    logic sect_erase;
    logic blk_erase;
    logic chip_erase;
  } srp_cmd_t;
endpackage

// File: rtl/srp_region_decode.sv
module srp_region_decode
  import srp_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int BLK_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              prot_o
);
  localparam int NUM_BLK = 1 << BLK_LOG2;
  localparam int BLK_SH  = ADDR_W - BLK_LOG2;

  logic [ADDR_W:0] floor_addr;
  int unsigned     span_log;

  always_comb begin
    floor_addr = '0;
    span_log   = 0;
    prot_o     = 1'b0;
    if (code_i != '0) begin
      span_log = int'(code_i) - 1;
      if (span_log >= BLK_LOG2) begin
        prot_o = 1'b1;
      end else begin
        floor_addr = (ADDR_W+1)'(NUM_BLK - (1 << span_log)) << BLK_SH;
        prot_o     = {1'b0, addr_i} >= floor_addr;
      end
    end
  end
endmodule

// File: rtl/srp_cmd_gate.sv
module srp_cmd_gate
  import srp_pkg::*;
(
  input  srp_cmd_t          cmd_i,
  input  logic              busy_i,
  input  logic              latch_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              lock_i,
  input  logic              wp_n_i,
  input  logic              prot_i,
  output logic              accept_o,
  output logic              reject_o
);
  logic addr_cmd, any_write, hw_frozen, ok;

  always_comb begin
    addr_cmd  = cmd_i.page_prog | cmd_i.sect_erase | cmd_i.blk_erase;
    any_write = addr_cmd | cmd_i.chip_erase | cmd_i.sr_write;
    hw_frozen = lock_i & ~wp_n_i;
    ok        = latch_i & ~busy_i;
    if (addr_cmd)              ok = ok & ~prot_i;
    else if (cmd_i.chip_erase) ok = ok & (code_i == '0);
    else if (cmd_i.sr_write)   ok = ok & ~hw_frozen;
    accept_o = any_write & ok;
    reject_o = any_write & ~ok;
  end
endmodule

// File: rtl/srp_status_regs.sv
module srp_status_regs
  import srp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              set_latch_i,
  input  logic              clr_latch_i,
  input  logic              start_i,
  input  logic              load_sr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              wr_lock_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              latch_o,
  output logic [CODE_W-1:0] code_o,
  output logic              lock_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_o  <= 1'b0;
      latch_o <= 1'b0;
      code_o  <= '0;
      lock_o  <= 1'b0;
    end else if (busy_o) begin
      if (done_i) begin
        busy_o  <= 1'b0;
        latch_o <= 1'b0;
      end
    end else begin
      if (start_i)          busy_o  <= 1'b1;
      if (set_latch_i)      latch_o <= 1'b1;
      else if (clr_latch_i) latch_o <= 1'b0;
      if (load_sr_i) begin
        code_o <= wr_code_i;
        lock_o <= wr_lock_i;
      end
    end
  end

  // R9
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && done_i) |=> (!busy_o && !latch_o));
  // R2
  latch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!busy_o && set_latch_i) |=> latch_o);
endmodule

// File: rtl/srp_status_guard.sv
module srp_status_guard
  import srp_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int BLK_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              set_latch_i,
  input  logic              clr_latch_i,
  input  logic              sr_write_i,
  input  logic              page_prog_i,
  input  logic              sect_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        wr_code_i,
  input  logic              wr_lock_i,
  input  logic              wp_n_i,
  input  logic              cycle_done_i,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              prot_o
);
  srp_cmd_t          cmd;
  logic              busy, latch, lock, prot;
  logic [CODE_W-1:0] code;
  logic              acc_d, rej_d, acc_q, rej_q;

  assign cmd = '{set_latch: set_latch_i, clr_latch: clr_latch_i,
                 sr_write: sr_write_i, page_prog: page_prog_i,
                 sect_erase: sect_erase_i, blk_erase: blk_erase_i,
                 chip_erase: chip_erase_i};

  srp_region_decode #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_region (
    .addr_i (addr_i),
    .code_i (code),
    .prot_o (prot)
  );

  srp_cmd_gate u_gate (
    .cmd_i    (cmd),
    .busy_i   (busy),
    .latch_i  (latch),
    .code_i   (code),
    .lock_i   (lock),
    .wp_n_i   (wp_n_i),
    .prot_i   (prot),
    .accept_o (acc_d),
    .reject_o (rej_d)
  );

  srp_status_regs u_regs (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .set_latch_i (set_latch_i),
    .clr_latch_i (clr_latch_i),
    .start_i     (acc_d),
    .load_sr_i   (acc_d & sr_write_i),
    .wr_code_i   (wr_code_i),
    .wr_lock_i   (wr_lock_i),
    .done_i      (cycle_done_i),
    .busy_o      (busy),
    .latch_o     (latch),
    .code_o      (code),
    .lock_o      (lock)
  );

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      rej_q <= rej_d;
    end
  end

  always_comb begin
    status_o                                  = '0;
    status_o[BIT_BUSY]                        = busy;
    status_o[BIT_LATCH]                       = latch;
    status_o[BIT_CODE_LO +: CODE_W]           = code;
    status_o[BIT_LOCK]                        = lock;
  end

  assign accept_o = acc_q;
  assign reject_o = rej_q;
  assign prot_o   = prot;

  logic any_write, addr_cmd;
  assign addr_cmd  = page_prog_i | sect_erase_i | blk_erase_i;
  assign any_write = addr_cmd | chip_erase_i | sr_write_i;

  // R11
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(cmd));
  // R10
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy && any_write) |=> reject_o);
  // R3
  latch_needed_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!latch && any_write) |=> (reject_o && $stable(status_o)));
  // R5
  prot_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (addr_cmd && prot_o && !busy) |=> (reject_o && $stable(latch)));
  // R6
  chip_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (chip_erase_i && code != '0) |=> reject_o);
  // R7
  hw_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sr_write_i && lock && !wp_n_i) |=> (reject_o && $stable(code) && $stable(lock)));
  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    accept_o |-> (busy && !reject_o));
endmodule

// File: tb/srp_status_guard_tb.sv
module srp_status_guard_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_l = 0, clr_l = 0, srw = 0, pp = 0, se = 0, be = 0, ce = 0;
  logic [AW-1:0] addr = '0;
  logic [2:0]    wcode = '0;
  logic          wlock = 1'b0, wp_n = 1'b1, done = 1'b0;
  logic [7:0]    status;
  logic          acc, rej, prot;

  int checks = 0, fails = 0;
  bit m_busy, m_latch, m_lock, m_acc, m_rej;
  int m_code;
  string cur;

  always #4 clk = ~clk;

  srp_status_guard #(.ADDR_W(AW), .BLK_LOG2(2)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .set_latch_i(set_l), .clr_latch_i(clr_l),
    .sr_write_i(srw), .page_prog_i(pp), .sect_erase_i(se), .blk_erase_i(be),
    .chip_erase_i(ce), .addr_i(addr), .wr_code_i(wcode), .wr_lock_i(wlock),
    .wp_n_i(wp_n), .cycle_done_i(done), .status_o(status), .accept_o(acc),
    .reject_o(rej), .prot_o(prot));

  function automatic bit model_prot(int a, int c);
    int quarter;
    quarter = a / (1 << (AW - 2));
    if (c == 0) return 0;
    if (c == 1) return quarter == 3;
    if (c == 2) return quarter >= 2;
    return 1;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("status", status, {m_lock, 2'b00, 3'(m_code), m_latch, m_busy});
    chk("accept", acc, m_acc);
    chk("reject", rej, m_rej);
    chk("prot", prot, model_prot(addr, m_code));
  endtask

  task automatic model_edge();
    bit addr_c, wr, ok;
    addr_c = pp | se | be;
    wr = addr_c | ce | srw;
    ok = m_latch && !m_busy;
    if (addr_c) ok = ok && !model_prot(addr, m_code);
    else if (ce) ok = ok && (m_code == 0);
    else if (srw) ok = ok && !(m_lock && !wp_n);
    m_acc = wr && ok;
    m_rej = wr && !ok;
    if (m_busy) begin
      if (done) begin m_busy = 0; m_latch = 0; end
    end else begin
      if (m_acc) m_busy = 1;
      if (set_l) m_latch = 1;
      else if (clr_l) m_latch = 0;
      if (m_acc && srw) begin m_code = wcode; m_lock = wlock; end
    end
  endtask

  task automatic step(string tag);
    cur = tag;
    @(posedge clk);
    model_edge();
    #2;
    compare();
    @(negedge clk);
    {set_l, clr_l, srw, pp, se, be, ce, done} = '0;
  endtask

  task automatic sr_write(string tag, int c, bit l);
    set_l = 1; step(tag);
    srw = 1; wcode = 3'(c); wlock = l; step(tag);
    done = 1; step(tag);
  endtask

  initial begin
    #50000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur = "R1";
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare();
    // R3: writes with latch clear
    pp = 1; step("R3");
    srw = 1; wcode = 3'd7; wlock = 1; step("R3");
    ce = 1; step("R3");
    // R2: set and clear latch
    set_l = 1; step("R2");
    clr_l = 1; step("R2");
    set_l = 1; step("R2");
    // R8: status write accepted, busy, readable
    srw = 1; wcode = 3'd2; wlock = 0; step("R8");
    step("R8");
    set_l = 1; step("R2");
    clr_l = 1; step("R2");
    pp = 1; addr = 0; step("R10");
    srw = 1; step("R10");
    done = 1; step("R9");
    // R4: decode sweep over all codes and quarters
    for (int c = 0; c < 8; c++) begin
      sr_write("R4", c, 0);
      for (int q = 0; q < 4; q++) begin
        addr = AW'(q * (1 << (AW - 2)) + 5); step("R4");
        addr = AW'((q + 1) * (1 << (AW - 2)) - 1); step("R4");
      end
    end
    // R5: protected target keeps latch
    sr_write("R5", 1, 0);
    set_l = 1; step("R5");
    addr = AW'(3 << (AW - 2)); pp = 1; step("R5");
    se = 1; step("R5");
    be = 1; step("R5");
    addr = AW'(2 << (AW - 2)) + 7; be = 1; step("R5");
    done = 1; step("R9");
    // R6: chip erase needs code 0
    set_l = 1; step("R6");
    ce = 1; step("R6");
    done = 1; step("R9");
    sr_write("R6", 0, 0);
    set_l = 1; step("R6");
    ce = 1; step("R6");
    done = 1; step("R9");
    // R7: hardware freeze
    sr_write("R7", 1, 1);
    wp_n = 0;
    set_l = 1; step("R7");
    srw = 1; wcode = 3'd0; wlock = 0; step("R7");
    step("R7");
    wp_n = 1;
    srw = 1; wcode = 3'd0; wlock = 0; step("R7");
    done = 1; step("R7");
    // R11: completion coincides with new commands
    set_l = 1; step("R11");
    sect_erase_go();
    done = 1; set_l = 1; step("R11");
    set_l = 1; step("R11");
    pp = 1; addr = 0; step("R11");
    done = 1; pp = 1; step("R11");
    step("R11");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic sect_erase_go();
    se = 1; addr = 0; step("R8");
  endtask
endmodule